// File: doc/BRIEF.md
# SPI clock and select timing generator

This block produces the serial clock and the device-select line for a flash-read SPI master that runs from a much faster system clock. A sequencer requests a transfer with a start pulse. The block asserts select, waits a programmable lead time, and then produces clock pulses whose low and high phases are each counted separately in system clocks. It repeats pulses until the sequencer marks the final bit. Select then drops, and a programmable trailing idle time must pass before a new transfer is accepted.

The sequencer does not watch the clock pin. It follows two single-cycle strobes instead: one marks where data is launched (the start of every low phase) and one marks where data is sampled. Only SPI modes 0 and 3 are supported, and data is always sampled on the rising clock edge. An optional feedback timing mode moves the sample strobe to model a returned clock that arrives late, either as is or inverted. Data shifting, command framing and pad control are outside this block.

Top module: `spi_clk_sel_gen`

## Requirements
- R1: Every low phase of the serial clock lasts `cfg_lo_len_i` system clocks, and the value 0 means 16 clocks.
- R2: Every high phase of the serial clock lasts `cfg_hi_len_i` system clocks, and the value 0 means 16 clocks.
- R3: When `cfg_mode_i` is 3 the clock idles high. Any other value (0, and the illegal values 1 and 2) makes it idle low. The idle level is held in reset, before the first low phase and after the last high phase.
- R4: When `cfg_sel_pol_i` is 0, `sel_o` is high while asserted. When it is 1, `sel_o` is low while asserted. The deasserted level is held in reset and when no transfer is running.
- R5: `sel_o` asserts in the cycle after the clock edge that samples `start_i` high. The first low phase begins after a lead time set by `cfg_lead_code_i`: codes 3, 2, 1 and 0 give 8, 4, 2 and 0 cycles. With 0 cycles the low phase begins in the same cycle that select asserts.
- R6: `launch_stb_o` is high for exactly the first cycle of every low phase. With feedback off, `sample_stb_o` is high for exactly the cycle in which the clock goes high.
- R7: With `cfg_fb_en_i` high, the sample strobe comes one system clock later than its edge. With `cfg_fb_inv_i` low that edge is the rising edge. With `cfg_fb_inv_i` high it is the first cycle after a high phase ends.
- R8: If `last_bit_i` is seen high at any time during the low or high phase of a bit, that bit is the last one. `sel_o` deasserts in the cycle after that bit's high phase.
- R9: After a transfer, `sel_o` stays deasserted and the clock idles for the number of cycles set by `cfg_trail_code_i`: codes 0, 1, 2 and 3 give 1, 3, 5 and 9 cycles.
- R10: A `start_i` pulse has no effect during lead, clock pulses or any trailing cycle but the last. A start seen at the edge ending the last trailing cycle is accepted, so select reasserts right after exactly the trailing idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer request, sampled at rising clk |
| last_bit_i | input | 1 | Sequencer marks the current bit as the final one |
| cfg_mode_i | input | 2 | SPI mode, 0 or 3 |
| cfg_sel_pol_i | input | 1 | Select polarity, 0 active high, 1 active low |
| cfg_lo_len_i | input | PHASE_W | Low-phase length in system clocks, 0 means 2^PHASE_W |
| cfg_hi_len_i | input | PHASE_W | High-phase length in system clocks, 0 means 2^PHASE_W |
| cfg_lead_code_i | input | 2 | Lead-time code |
| cfg_trail_code_i | input | 2 | Trailing-idle code |
| cfg_fb_en_i | input | 1 | Feedback sample timing enable |
| cfg_fb_inv_i | input | 1 | Feedback sampling on the inverted clock |
| sclk_o | output | 1 | Serial clock |
| sel_o | output | 1 | Device select |
| launch_stb_o | output | 1 | One-cycle launch strobe |
| sample_stb_o | output | 1 | One-cycle sample strobe |

## Verification
All outputs are decoded from registered state, so every result appears in the cycle after the clock edge that caused it. Select appears one cycle after start is sampled. The first low phase appears one lead time after that. Each strobe appears in the same cycle as its clock edge, or one cycle later in feedback mode. For each transfer the bench builds an expected timeline, cycle by cycle, from the programmed lengths and codes. It compares all four outputs at the falling clock edge in the middle of every cycle. It changes `start_i` and `last_bit_i` only after the comparison for that cycle, so each input takes effect at the following rising edge, as the requirements state.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LEAD  = 3'd1,
      ST_LOW   = 3'd2,
      ST_HIGH  = 3'd3,
      ST_TRAIL = 3'd4
   } tg_state_e;

   // lead time in system clocks for a 2-bit code
   function automatic logic [3:0] lead_clocks(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd0;
         2'd1:    return 4'd2;
         2'd2:    return 4'd4;
         default: return 4'd8;
      endcase
   endfunction

   // trailing idle time in system clocks for a 2-bit code
   function automatic logic [3:0] trail_clocks(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd1;
         2'd1:    return 4'd3;
         2'd2:    return 4'd5;
         default: return 4'd9;
      endcase
   endfunction

endpackage

// File: rtl/spi_tg_timer.sv
module spi_tg_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/spi_tg_seq.sv
module spi_tg_seq
   import spi_tg_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             last_bit_i,
   input  logic             idle_hi_i,
   input  logic             lead_skip_i,
   input  logic [CNT_W-1:0] lead_ld_i,
   input  logic [CNT_W-1:0] lo_ld_i,
   input  logic [CNT_W-1:0] hi_ld_i,
   input  logic [CNT_W-1:0] trail_ld_i,
   output logic             sel_act_o,
   output logic             sclk_o,
   output logic             launch_o,
   output logic             rise_o,
   output logic             fall_o
);

   tg_state_e        st_q, st_nx;
   logic             first_q, last_q, fall_q;
   logic             ld;
   logic [CNT_W-1:0] ld_val;
   logic             zero;
   logic             take;
   logic             in_run;

   spi_tg_timer #(.W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ld),
      .val_i  (ld_val),
      .zero_o (zero)
   );

   assign take   = start_i && ((st_q == ST_IDLE) || ((st_q == ST_TRAIL) && zero));
   assign in_run = (st_q == ST_LOW) || (st_q == ST_HIGH);

   always_comb begin
      st_nx  = st_q;
      ld     = 1'b0;
      ld_val = '0;
      if (take) begin
         ld = 1'b1;
         if (lead_skip_i) begin
            st_nx  = ST_LOW;
            ld_val = lo_ld_i;
         end else begin
            st_nx  = ST_LEAD;
            ld_val = lead_ld_i;
         end
      end else begin
         case (st_q)
            ST_LEAD: if (zero) begin
               st_nx  = ST_LOW;
               ld     = 1'b1;
               ld_val = lo_ld_i;
            end
            ST_LOW: if (zero) begin
               st_nx  = ST_HIGH;
               ld     = 1'b1;
               ld_val = hi_ld_i;
            end
            ST_HIGH: if (zero) begin
               ld = 1'b1;
               if (last_q || last_bit_i) begin
                  st_nx  = ST_TRAIL;
                  ld_val = trail_ld_i;
               end else begin
                  st_nx  = ST_LOW;
                  ld_val = lo_ld_i;
               end
            end
            ST_TRAIL: if (zero) st_nx = ST_IDLE;
            default: st_nx = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         first_q <= 1'b0;
         last_q  <= 1'b0;
         fall_q  <= 1'b0;
      end else begin
         st_q    <= st_nx;
         first_q <= ld;
         fall_q  <= (st_q == ST_HIGH) && zero;
         if (take)
            last_q <= 1'b0;
         else if (in_run && last_bit_i)
            last_q <= 1'b1;
      end
   end

   assign sel_act_o = (st_q == ST_LEAD) || in_run;
   assign sclk_o    = idle_hi_i ? (st_q != ST_LOW) : (st_q == ST_HIGH);
   assign launch_o  = (st_q == ST_LOW) && first_q;
   assign rise_o    = (st_q == ST_HIGH) && first_q;
   assign fall_o    = fall_q;

   // R10: a trailing period that is not finished always continues
   p_trail_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TRAIL && !zero) |=> (st_q == ST_TRAIL));

   // R8: select only drops right after a high phase
   p_sel_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_act_o) |-> ($past(st_q) == ST_HIGH));

   // R5: the lead state is never visited when the lead code means zero cycles
   p_lead_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LEAD) |-> !lead_skip_i);

endmodule

// File: rtl/spi_tg_sample.sv
module spi_tg_sample #(
   parameter int FB_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_i,
   input  logic fall_i,
   input  logic sclk_i,
   input  logic fb_en_i,
   input  logic fb_inv_i,
   output logic sample_o
);

   logic evt;
   logic dly_out;

   assign evt = fb_inv_i ? fall_i : rise_i;

   generate
      if (FB_LAT == 1) begin : g_single
         logic dly_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dly_q <= 1'b0;
            else        dly_q <= evt;
         end
         assign dly_out = dly_q;
      end else begin : g_chain
         logic [FB_LAT-1:0] dly_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dly_q <= '0;
            else        dly_q <= {dly_q[FB_LAT-2:0], evt};
         end
         assign dly_out = dly_q[FB_LAT-1];
      end
   endgenerate

   assign sample_o = fb_en_i ? dly_out : rise_i;

   // R6: without feedback, sampling lines up with a rising serial clock
   p_sample_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!fb_en_i && sample_o) |-> (sclk_i && !$past(sclk_i)));

endmodule

// File: rtl/spi_clk_sel_gen.sv
module spi_clk_sel_gen
   import spi_tg_pkg::*;
#(
   parameter int PHASE_W = 4,
   parameter int FB_LAT  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               last_bit_i,
   input  logic [1:0]         cfg_mode_i,
   input  logic               cfg_sel_pol_i,
   input  logic [PHASE_W-1:0] cfg_lo_len_i,
   input  logic [PHASE_W-1:0] cfg_hi_len_i,
   input  logic [1:0]         cfg_lead_code_i,
   input  logic [1:0]         cfg_trail_code_i,
   input  logic               cfg_fb_en_i,
   input  logic               cfg_fb_inv_i,
   output logic               sclk_o,
   output logic               sel_o,
   output logic               launch_stb_o,
   output logic               sample_stb_o
);

   localparam int CNT_W = (PHASE_W > 4) ? PHASE_W : 4;

   generate
      if (PHASE_W < 2 || PHASE_W > 8) begin : g_bad_phase_w
         $error("spi_clk_sel_gen: PHASE_W must lie in 2..8");
      end
      if (FB_LAT < 1 || FB_LAT > 8) begin : g_bad_fb_lat
         $error("spi_clk_sel_gen: FB_LAT must lie in 1..8");
      end
   endgenerate

   logic               idle_hi;
   logic [PHASE_W-1:0] lo_m1, hi_m1;
   logic [3:0]         lead_n, trail_n;
   logic [CNT_W-1:0]   lo_ld, hi_ld, lead_ld, trail_ld;
   logic               sel_act, rise, fall;

   assign idle_hi  = (cfg_mode_i == 2'd3);
   // a length of zero wraps to all ones: 2^PHASE_W cycles
   assign lo_m1    = cfg_lo_len_i - 1'b1;
   assign hi_m1    = cfg_hi_len_i - 1'b1;
   assign lo_ld    = CNT_W'(lo_m1);
   assign hi_ld    = CNT_W'(hi_m1);
   assign lead_n   = lead_clocks(cfg_lead_code_i);
   assign trail_n  = trail_clocks(cfg_trail_code_i);
   assign lead_ld  = CNT_W'(lead_n - 4'd1);
   assign trail_ld = CNT_W'(trail_n - 4'd1);

   spi_tg_seq #(.CNT_W(CNT_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .last_bit_i  (last_bit_i),
      .idle_hi_i   (idle_hi),
      .lead_skip_i (lead_n == 4'd0),
      .lead_ld_i   (lead_ld),
      .lo_ld_i     (lo_ld),
      .hi_ld_i     (hi_ld),
      .trail_ld_i  (trail_ld),
      .sel_act_o   (sel_act),
      .sclk_o      (sclk_o),
      .launch_o    (launch_stb_o),
      .rise_o      (rise),
      .fall_o      (fall)
   );

   spi_tg_sample #(.FB_LAT(FB_LAT)) u_sample (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_i   (rise),
      .fall_i   (fall),
      .sclk_i   (sclk_o),
      .fb_en_i  (cfg_fb_en_i),
      .fb_inv_i (cfg_fb_inv_i),
      .sample_o (sample_stb_o)
   );

   assign sel_o = sel_act ^ cfg_sel_pol_i;

   // R6: a launch strobe only appears with select asserted and the clock low
   p_launch_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      launch_stb_o |-> (!sclk_o && sel_act));

   // R3: with no transfer running the clock sits at the mode's idle level
   p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_act && !$past(sel_act)) |-> (sclk_o == idle_hi));

endmodule

// File: tb/test_spi_clk_sel_gen.sv
`timescale 1ns/1ps
module test_spi_clk_sel_gen;

   localparam int PW   = 4;
   localparam int NMAX = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          last_bit_i = 1'b0;
   logic [1:0]    cfg_mode = 2'd0;
   logic          cfg_pol = 1'b0;
   logic [PW-1:0] cfg_lo = 4'd1;
   logic [PW-1:0] cfg_hi = 4'd1;
   logic [1:0]    cfg_lead = 2'd0;
   logic [1:0]    cfg_trail = 2'd0;
   logic          cfg_fb = 1'b0;
   logic          cfg_inv = 1'b0;
   logic          sclk_o, sel_o, launch_o, sample_o;

   int n_vec = 0;
   int n_bad = 0;

   logic e_sclk   [NMAX];
   logic e_act    [NMAX];
   logic e_launch [NMAX];
   logic e_sample [NMAX];
   int   e_kind   [NMAX];

   always #2 clk = ~clk;

   spi_clk_sel_gen #(.PHASE_W(PW), .FB_LAT(1)) i_spi_clk_sel_gen (
      .clk              (clk),
      .rst_n            (rst_n),
      .start_i          (start_i),
      .last_bit_i       (last_bit_i),
      .cfg_mode_i       (cfg_mode),
      .cfg_sel_pol_i    (cfg_pol),
      .cfg_lo_len_i     (cfg_lo),
      .cfg_hi_len_i     (cfg_hi),
      .cfg_lead_code_i  (cfg_lead),
      .cfg_trail_code_i (cfg_trail),
      .cfg_fb_en_i      (cfg_fb),
      .cfg_fb_inv_i     (cfg_inv),
      .sclk_o           (sclk_o),
      .sel_o            (sel_o),
      .launch_stb_o     (launch_o),
      .sample_stb_o     (sample_o)
   );

   task automatic check1(input string req, input string what, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int lead_n(input logic [1:0] c);
      case (c) 2'd0: return 0; 2'd1: return 2; 2'd2: return 4; default: return 8; endcase
   endfunction

   function automatic int trail_n(input logic [1:0] c);
      case (c) 2'd0: return 1; 2'd1: return 3; 2'd2: return 5; default: return 9; endcase
   endfunction

   function automatic string kind_tag(input int k);
      case (k) 0: return "R5"; 1: return "R1"; 2: return "R2"; 3: return "R9"; default: return "R3";
      endcase
   endfunction

   // One transfer: build the expected timeline, then compare every cycle.
   task automatic run_xfer(input logic [1:0] mode, input logic pol,
                           input logic [PW-1:0] lo, input logic [PW-1:0] hi,
                           input logic [1:0] lead, input logic [1:0] trail,
                           input logic fb, input logic inv, input int nbits,
                           input bit poke, input bit hold);
      int  lc = lead_n(lead);
      int  tc = trail_n(trail);
      int  lo_n = (lo == 0) ? 16 : int'(lo);
      int  hi_n = (hi == 0) ? 16 : int'(hi);
      logic idle = (mode == 2'd3);
      int  idx = 1;
      int  fl0 = 0, last_low = 0, tr_first, tr_end, kmax;
      for (int i = 0; i < NMAX; i++) begin
         e_sclk[i] = idle; e_act[i] = 1'b0; e_launch[i] = 1'b0;
         e_sample[i] = 1'b0; e_kind[i] = 4;
      end
      for (int k = 0; k < lc; k++) begin
         e_sclk[idx] = idle; e_act[idx] = 1'b1; e_kind[idx] = 0; idx++;
      end
      fl0 = idx;
      for (int b = 0; b < nbits; b++) begin
         int r;
         if (b == nbits - 1) last_low = idx;
         for (int k = 0; k < lo_n; k++) begin
            e_sclk[idx] = 1'b0; e_act[idx] = 1'b1; e_kind[idx] = 1;
            e_launch[idx] = (k == 0); idx++;
         end
         r = idx;
         for (int k = 0; k < hi_n; k++) begin
            e_sclk[idx] = 1'b1; e_act[idx] = 1'b1; e_kind[idx] = 2; idx++;
         end
         if (!fb)      e_sample[r] = 1'b1;
         else if (!inv) e_sample[r + 1] = 1'b1;
         else          e_sample[idx + 1] = 1'b1;
      end
      tr_first = idx;
      for (int k = 0; k < tc; k++) begin
         e_kind[idx] = 3; idx++;
      end
      tr_end = idx - 1;
      kmax = hold ? tr_end : idx + 3;

      cfg_mode = mode; cfg_pol = pol; cfg_lo = lo; cfg_hi = hi;
      cfg_lead = lead; cfg_trail = trail; cfg_fb = fb; cfg_inv = inv;
      @(negedge clk);
      start_i = 1'b1;
      @(posedge clk);
      for (int c = 1; c <= kmax; c++) begin
         @(negedge clk);
         check1(kind_tag(e_kind[c]), "sclk", sclk_o, e_sclk[c]);
         check1((c == tr_first) ? "R8" : kind_tag(e_kind[c]), "sel", sel_o, e_act[c] ^ pol);
         check1("R6", "launch", launch_o, e_launch[c]);
         check1(fb ? "R7" : "R6", "sample", sample_o, e_sample[c]);
         if (c == 1) start_i = 1'b0;
         // R10: pulses during a running transfer and early trail must be ignored
         if (poke && c == fl0) start_i = 1'b1;
         if (poke && c == fl0 + 1) start_i = 1'b0;
         if (poke && tc > 1 && c == tr_first) start_i = 1'b1;
         if (poke && tc > 1 && c == tr_first + 1) start_i = 1'b0;
         if (hold && c == tr_first) start_i = 1'b1;
         if (c == last_low) last_bit_i = 1'b1;
         if (c == tr_first) last_bit_i = 1'b0;
      end
      if (hold) begin
         @(negedge clk);
         check1("R10", "sel re-asserted right after trail", sel_o, ~pol);
         start_i = 1'b0;
         last_bit_i = 1'b1;
         repeat (60) @(negedge clk);
         last_bit_i = 1'b0;
         check1("R8", "sel back to idle after one-bit transfer", sel_o, pol);
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic t_reset_state;
      cfg_mode = 2'd3; cfg_pol = 1'b1;
      repeat (3) @(negedge clk);
      check1("R3", "sclk idle high in reset, mode 3", sclk_o, 1'b1);
      check1("R4", "sel deasserted (high) in reset, active low", sel_o, 1'b1);
      check1("R6", "launch quiet in reset", launch_o, 1'b0);
      check1("R6", "sample quiet in reset", sample_o, 1'b0);
      cfg_mode = 2'd0; cfg_pol = 1'b0;
      #1;
      check1("R3", "sclk idle low in reset, mode 0", sclk_o, 1'b0);
      check1("R4", "sel deasserted (low) in reset, active high", sel_o, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check1("R4", "sel stays deasserted after reset", sel_o, 1'b0);
   endtask

   task automatic t_mode0_basic;   // R1 R2 R6 R8
      run_xfer(2'd0, 1'b0, 4'd2, 4'd3, 2'd1, 2'd0, 1'b0, 1'b0, 3, 1'b0, 1'b0);
   endtask

   task automatic t_mode3_active_low;   // R3 R4
      run_xfer(2'd3, 1'b1, 4'd3, 4'd1, 2'd2, 2'd1, 1'b0, 1'b0, 4, 1'b0, 1'b0);
      run_xfer(2'd3, 1'b0, 4'd1, 4'd2, 2'd0, 2'd0, 1'b0, 1'b0, 2, 1'b0, 1'b0);
   endtask

   task automatic t_zero_lengths;   // R1 R2: zero means 16
      run_xfer(2'd0, 1'b0, 4'd0, 4'd0, 2'd0, 2'd0, 1'b0, 1'b0, 2, 1'b0, 1'b0);
      run_xfer(2'd3, 1'b1, 4'd0, 4'd5, 2'd1, 2'd0, 1'b0, 1'b0, 1, 1'b0, 1'b0);
   endtask

   task automatic t_lead_codes;   // R5
      for (int c = 0; c < 4; c++)
         run_xfer(2'd3, 1'b0, 4'd2, 4'd2, 2'(c), 2'd0, 1'b0, 1'b0, 1, 1'b0, 1'b0);
   endtask

   task automatic t_trail_codes;   // R9
      for (int c = 0; c < 4; c++)
         run_xfer(2'd0, 1'b1, 4'd1, 4'd1, 2'd1, 2'(c), 1'b0, 1'b0, 2, 1'b0, 1'b0);
   endtask

   task automatic t_feedback;   // R7
      run_xfer(2'd0, 1'b0, 4'd2, 4'd2, 2'd1, 2'd1, 1'b1, 1'b0, 3, 1'b0, 1'b0);
      run_xfer(2'd0, 1'b0, 4'd2, 4'd3, 2'd1, 2'd1, 1'b1, 1'b1, 3, 1'b0, 1'b0);
      run_xfer(2'd3, 1'b1, 4'd1, 4'd1, 2'd0, 2'd0, 1'b1, 1'b1, 2, 1'b0, 1'b0);
      run_xfer(2'd3, 1'b1, 4'd3, 4'd1, 2'd0, 2'd2, 1'b1, 1'b0, 2, 1'b0, 1'b0);
   endtask

   task automatic t_illegal_modes;   // R3: values 1 and 2 behave as mode 0
      run_xfer(2'd1, 1'b0, 4'd2, 4'd2, 2'd1, 2'd0, 1'b0, 1'b0, 2, 1'b0, 1'b0);
      run_xfer(2'd2, 1'b1, 4'd1, 4'd3, 2'd0, 2'd1, 1'b0, 1'b0, 2, 1'b0, 1'b0);
   endtask

   task automatic t_start_ignored;   // R10
      run_xfer(2'd0, 1'b0, 4'd2, 4'd2, 2'd2, 2'd3, 1'b0, 1'b0, 2, 1'b1, 1'b0);
      run_xfer(2'd3, 1'b1, 4'd1, 4'd2, 2'd0, 2'd2, 1'b0, 1'b0, 3, 1'b1, 1'b0);
   endtask

   task automatic t_back_to_back;   // R10
      run_xfer(2'd0, 1'b0, 4'd1, 4'd2, 2'd1, 2'd2, 1'b0, 1'b0, 2, 1'b0, 1'b1);
      run_xfer(2'd3, 1'b1, 4'd2, 4'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1, 1'b0, 1'b1);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      t_reset_state();
      t_mode0_basic();
      t_mode3_active_low();
      t_zero_lengths();
      t_lead_codes();
      t_trail_codes();
      t_feedback();
      t_illegal_modes();
      t_start_ignored();
      t_back_to_back();
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (R1..all): actual=timeout expected=completion");
      summary();
      $finish;
   end

endmodule